// File: doc/BRIEF.md
# Wide-to-Byte External Bus Sequencer

This block sits between a 32-bit internal request port and an external memory bus with an 8-bit data path and a 16-bit address. It accepts one request at a time: a byte, half-word or word, read or write. It runs the request as a chain of byte cycles, assembles read bytes into a right-aligned 32-bit result and pulses a completion flag when the last byte cycle has finished.

The request address has two parts. Its low 16 bits are the external base address. The bits above them select one of up to seven active-low chip-select lines. That line stays low for the whole access. Every byte cycle has an address clock followed by an active-low strobe clock. A wait setting adds 0 to 2 extra strobe clocks to every byte cycle of the access. Byte offset 0 holds the most significant byte of the value. Reads walk the offsets upward and writes walk them downward. In each byte cycle, write data stays on the bus for one clock after the strobe rises.

Top module: `narrow_bus_seq`

## Requirements
- R1: After synchronous reset: `req_ready`=1, all `ext_cs_n` bits 1, `ext_rd_n`=`ext_wr_n`=1, `ext_doe`=0, `done`=0, `rdata`=0.
- R2: `req_size` code 0 runs 1 byte cycle, code 1 runs 2 and codes 2 and 3 run 4. Each byte cycle is one clock with both strobes high, then 1+W clocks with the strobe low (`ext_rd_n` for reads, `ext_wr_n` for writes). The first byte cycle's address clock is the clock after the accepting edge.
- R3: Byte cycles of a read use offsets 0,1,..,n-1 in that order and writes use n-1,..,1,0. `ext_addr` = (`req_addr[15:0]` + offset) mod 65536 and holds for the whole byte cycle.
- R4: Offset k carries bits [8(n-1-k)+7 : 8(n-1-k)] of the n-byte value. A write sends the low n bytes of `req_wdata`. A read samples `ext_din` on the last strobe clock and returns the value in `rdata[8n-1:0]` with the upper bits zero.
- R5: W is `wait_cfg` sampled at acceptance. Values above 2 act as 2.
- R6: Region `req_addr[18:16]` = r with r < 7 drives `ext_cs_n[r]` low from the first address clock through the completion clock. Region 7 leaves all lines high. At most one line is ever low.
- R7: On writes, `ext_dout` shows the byte of the current cycle from its first strobe clock. It holds that byte through the clock after the strobe rises, and `ext_doe` stays 1 from the first strobe clock through the completion clock. Reads keep `ext_doe` at 0.
- R8: `done` is a one-clock pulse in the clock after the last strobe clock. `req_ready` is 1 only when idle and returns the clock after `done`. `req_valid` while busy is ignored.
- R9: `ext_rd_n` and `ext_wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 19 | [15:0] base address, [18:16] chip-select region |
| req_wdata | input | 32 | Write value, right aligned |
| wait_cfg | input | 2 | Extra strobe clocks per byte cycle (0..2) |
| req_ready | output | 1 | Idle, request would be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read value, right aligned |
| ext_addr | output | 16 | External byte address |
| ext_cs_n | output | 7 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_dout | output | 8 | Write data byte |
| ext_doe | output | 1 | Data bus drive enable |
| ext_din | input | 8 | Read data byte |

## Verification
The bench builds the block with its default parameters: a 16-bit external address, a 3-bit region field with seven selects, a 32-bit internal word and a 2-bit wait field capped at 2. Because the region field has one code more than there are select lines, the no-select case is reachable. The spare wait code exercises the clamp. The 16-bit address lets a word access near 0xFFFF show the address wrap.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_TAIL = 2'd3
  } nbs_phase_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/nbs_cs_decode.sv
module nbs_cs_decode #(
  parameter int SEL_W  = 3,
  parameter int NUM_CS = 7
) (
  input  logic [SEL_W-1:0]  region,
  output logic [NUM_CS-1:0] cs_n
);
  // One comparator per select line; region codes past NUM_CS select nothing.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_n[g] = (region != SEL_W'(g));
  end
endmodule

// File: rtl/nbs_byte_plan.sv
module nbs_byte_plan #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] last,
  input  logic             write,
  output logic [IDX_W-1:0] offset,
  output logic [IDX_W-1:0] lane
);
  // Reads walk offsets upward, writes downward; offset 0 is the top lane.
  always_comb begin
    offset = write ? (last - idx) : idx;
    lane   = last - offset;
  end
endmodule

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq
  import nbs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEL_W    = 3,
  parameter int NUM_CS   = 7,
  parameter int DATA_W   = 32,
  parameter int WAIT_W   = 2,
  parameter int MAX_WAIT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [1:0]              req_size,
  input  logic [ADDR_W+SEL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [WAIT_W-1:0]       wait_cfg,
  output logic                    req_ready,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata,
  output logic [ADDR_W-1:0]       ext_addr,
  output logic [NUM_CS-1:0]       ext_cs_n,
  output logic                    ext_rd_n,
  output logic                    ext_wr_n,
  output logic [7:0]              ext_dout,
  output logic                    ext_doe,
  input  logic [7:0]              ext_din
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  nbs_phase_t        phase;
  logic [IDX_W-1:0]  idx_q, last_q, lane_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAIT_W-1:0] wait_q, wcnt;

  logic [IDX_W-1:0]  req_last, sel_idx, sel_last, nx_off, nx_lane;
  logic              sel_wr;
  logic [WAIT_W-1:0] wait_eff;
  logic [NUM_CS-1:0] req_cs_n;
  int unsigned       req_nb;

  always_comb begin
    req_nb = 32'd1 << req_size;
    if (req_nb > BYTES) req_nb = BYTES;
    req_last = IDX_W'(req_nb - 1);
    wait_eff = (wait_cfg > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : wait_cfg;
  end

  // The plan looks one byte ahead: request in idle, next index otherwise.
  always_comb begin
    if (phase == PH_IDLE) begin
      sel_idx  = '0;
      sel_last = req_last;
      sel_wr   = req_write;
    end else begin
      sel_idx  = idx_q + 1'b1;
      sel_last = last_q;
      sel_wr   = wr_q;
    end
  end

  nbs_byte_plan #(.IDX_W(IDX_W)) u_plan (
    .idx    (sel_idx),
    .last   (sel_last),
    .write  (sel_wr),
    .offset (nx_off),
    .lane   (nx_lane)
  );

  nbs_cs_decode #(.SEL_W(SEL_W), .NUM_CS(NUM_CS)) u_csdec (
    .region (req_addr[ADDR_W+SEL_W-1:ADDR_W]),
    .cs_n   (req_cs_n)
  );

  assign req_ready = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      lane_q   <= '0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      wdata_q  <= '0;
      wait_q   <= '0;
      wcnt     <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      ext_addr <= '0;
      ext_cs_n <= '1;
      ext_rd_n <= 1'b1;
      ext_wr_n <= 1'b1;
      ext_dout <= '0;
      ext_doe  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase    <= PH_ADDR;
            wr_q     <= req_write;
            base_q   <= req_addr[ADDR_W-1:0];
            wdata_q  <= req_wdata;
            wait_q   <= wait_eff;
            last_q   <= req_last;
            idx_q    <= '0;
            lane_q   <= nx_lane;
            rdata    <= '0;
            ext_addr <= req_addr[ADDR_W-1:0] + ADDR_W'(nx_off);
            ext_cs_n <= req_cs_n;
          end
        end
        PH_ADDR: begin
          phase <= PH_STRB;
          wcnt  <= wait_q;
          if (wr_q) begin
            ext_wr_n <= 1'b0;
            ext_dout <= wdata_q[8*lane_q +: 8];
            ext_doe  <= 1'b1;
          end else begin
            ext_rd_n <= 1'b0;
          end
        end
        PH_STRB: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else begin
            ext_rd_n <= 1'b1;
            ext_wr_n <= 1'b1;
            if (!wr_q) rdata[8*lane_q +: 8] <= ext_din;
            if (idx_q == last_q) begin
              phase <= PH_TAIL;
              done  <= 1'b1;
            end else begin
              phase    <= PH_ADDR;
              idx_q    <= idx_q + 1'b1;
              lane_q   <= nx_lane;
              ext_addr <= base_q + ADDR_W'(nx_off);
            end
          end
        end
        PH_TAIL: begin
          phase    <= PH_IDLE;
          ext_cs_n <= '1;
          ext_doe  <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: never more than one select line low
  a_r6_one_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_cs_n));
  // R9: strobes mutually exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));
  // R3: address steady across consecutive strobe clocks
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(!ext_rd_n || !ext_wr_n) && (!ext_rd_n || !ext_wr_n)) |-> $stable(ext_addr));
  // R7: write byte held and driven through the clock after the strobe
  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!ext_wr_n) |-> ($stable(ext_dout) && ext_doe));
  // R8: completion follows a strobe clock and lasts one clock
  a_r8_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!ext_rd_n || !ext_wr_n));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: idle bus is quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&ext_cs_n && ext_rd_n && ext_wr_n && !ext_doe));
  // R5: wait counter never exceeds the latched setting
  a_r5_wait_bound: assert property (@(posedge clk) disable iff (rst)
    (wcnt <= wait_q) && (wait_q <= WAIT_W'(MAX_WAIT)));
endmodule

// File: tb/narrow_bus_seq_tb.sv
`timescale 1ns/1ps
module narrow_bus_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0, wait_cfg = '0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, ext_rd_n, ext_wr_n, ext_doe;
  logic [31:0] rdata;
  logic [15:0] ext_addr;
  logic [6:0]  ext_cs_n;
  logic [7:0]  ext_dout, ext_din;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h3C;
  endfunction

  assign ext_din = mem_fn(ext_addr);

  narrow_bus_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_cfg(wait_cfg), .req_ready(req_ready), .done(done), .rdata(rdata),
    .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int size_bytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int exec_off(input bit wr, input int n, input int j);
    return wr ? (n - 1 - j) : j;
  endfunction

  function automatic logic [7:0] off_byte(input logic [31:0] v, input int n, input int o);
    return v[8*(n-1-o) +: 8];
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] base, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[8*(n-1-k) +: 8] = mem_fn(base + 16'(k));
    return r;
  endfunction

  task automatic run_access(input bit wr, input logic [1:0] sz, input logic [18:0] addr,
                            input logic [31:0] wd, input logic [1:0] wc, input bit noise);
    int n, w, per, tdone, pos, j, o;
    logic [6:0]  exp_cs;
    logic [15:0] base, exp_a;
    logic [1:0]  exp_st;
    n = size_bytes(sz);
    w = (wc > 2'd2) ? 2 : int'(wc);
    per = 2 + w;
    tdone = n * per + 1;
    base = addr[15:0];
    exp_cs = '1;
    if (addr[18:16] < 3'd7) exp_cs[addr[18:16]] = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr;
    req_wdata = wd; wait_cfg = wc;
    for (int s = 1; s <= tdone + 1; s++) begin
      @(negedge clk);
      if (noise && s < tdone) begin
        req_valid = 1'b1; req_write = ~wr; req_size = $urandom;
        req_addr = $urandom; req_wdata = $urandom; wait_cfg = $urandom;
      end else begin
        req_valid = 1'b0;
      end
      if (s <= tdone) begin
        chk(ext_cs_n == exp_cs, "R6 chip select during access", {25'd0, ext_cs_n}, {25'd0, exp_cs});
        chk(req_ready == 1'b0 && done == (s == tdone), "R8 ready/done timing",
            {30'd0, req_ready, done}, {31'd0, 1'(s == tdone)});
      end
      if (s < tdone) begin
        pos = (s - 1) % per;
        j = (s - 1) / per;
        o = exec_off(wr, n, j);
        exp_a = base + 16'(o);
        exp_st = (pos >= 1) ? (wr ? 2'b10 : 2'b01) : 2'b11;
        chk({ext_rd_n, ext_wr_n} == exp_st, "R2 strobe shape (R5 wait)",
            {30'd0, ext_rd_n, ext_wr_n}, {30'd0, exp_st});
        chk(ext_addr == exp_a, "R3 byte address order", {16'd0, ext_addr}, {16'd0, exp_a});
        if (wr && pos >= 1)
          chk(ext_dout == off_byte(wd, n, o) && ext_doe, "R4 write byte on bus",
              {23'd0, ext_doe, ext_dout}, {24'd1, off_byte(wd, n, o)});
        else if (wr && j > 0)
          chk(ext_dout == off_byte(wd, n, exec_off(wr, n, j - 1)) && ext_doe,
              "R7 write data hold", {23'd0, ext_doe, ext_dout},
              {24'd1, off_byte(wd, n, exec_off(wr, n, j - 1))});
        else if (!wr)
          chk(!ext_doe, "R7 no drive on read", {31'd0, ext_doe}, 32'd0);
      end else if (s == tdone) begin
        chk(ext_rd_n && ext_wr_n, "R9 strobes high at completion",
            {30'd0, ext_rd_n, ext_wr_n}, 32'd3);
        if (wr)
          chk(ext_dout == off_byte(wd, n, 0) && ext_doe, "R7 last write byte hold",
              {23'd0, ext_doe, ext_dout}, {24'd1, off_byte(wd, n, 0)});
        else
          chk(rdata == exp_read(base, n), "R4 read assembly", rdata, exp_read(base, n));
      end else begin
        chk(req_ready && !done && ext_cs_n == 7'h7F && !ext_doe, "R8 return to idle",
            {23'd0, req_ready, done, ext_cs_n}, {23'd0, 2'b10, 7'h7F});
        if (!wr)
          chk(rdata == exp_read(base, n), "R4 read result held", rdata, exp_read(base, n));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && ext_cs_n == 7'h7F && ext_rd_n && ext_wr_n && !ext_doe,
        "R1 reset outputs", {21'd0, req_ready, done, ext_cs_n, ext_rd_n, ext_wr_n, ext_doe},
        {21'd0, 2'b10, 7'h7F, 3'b110});
    chk(rdata == 32'd0, "R1 reset rdata", rdata, 32'd0);

    run_access(1'b0, 2'd2, 19'h0FFFE, 32'd0, 2'd0, 1'b0);          // R3 wrap, word read
    run_access(1'b1, 2'd2, 19'h61234, 32'hA1B2C3D4, 2'd2, 1'b0);   // R7 word write, wait 2
    run_access(1'b0, 2'd1, 19'h7ABCD, 32'd0, 2'd1, 1'b0);          // R6 region 7, no select
    run_access(1'b1, 2'd3, 19'h30010, 32'h11223344, 2'd3, 1'b0);   // R2 code 3, R5 clamp
    run_access(1'b1, 2'd0, 19'h000FF, 32'h000000EE, 2'd1, 1'b0);   // R2 single byte
    run_access(1'b0, 2'd2, 19'h24444, 32'd0, 2'd1, 1'b1);          // R8 busy requests ignored
    run_access(1'b1, 2'd1, 19'h5FFFF, 32'h0000BEEF, 2'd0, 1'b1);   // R3 half write wrap

    for (int t = 0; t < 300; t++) begin
      logic [31:0] r;
      r = $urandom;
      run_access(r[0], r[2:1], 19'($urandom), $urandom, r[4:3], r[5]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule